// File: doc/BRIEF.md
# Shared-Bus Register Transfer Unit

This block holds a small bank of equal-width registers that exchange data over a single internal bus. Each cycle, a one-hot read-enable vector chooses which register places its contents on the bus. A load-enable vector chooses which registers capture the bus value at the next rising clock edge. A register-to-register move therefore takes one cycle. It works in either direction and between any pair of registers, always through the same path.

The bus is built as a select-and-merge multiplexer, not as tri-state wiring. The block classifies every cycle into one of three states:

- **Driven:** exactly one source is enabled, and the bus value is valid.
- **Floating:** no source is enabled.
- **Contention:** more than one source is enabled.

In the floating and contention states the bus carries zero, and every bus load is blocked. A separate direct write port lets the surrounding logic seed any register with a value. A direct write to a register wins over a bus load to that same register in the same cycle.

Top module: `xfer_bus_unit`

## Requirements
- R1: While `rst` is high at a rising edge, every register becomes zero at that edge.
- R2: When exactly one bit `i` of `rd_en` is set, `bus_valid` is 1 and `bus_data` equals register `i` in the same cycle. Register `i` is `regs_flat[i*DW +: DW]`.
- R3: When the bus is valid, each register whose `ld_en` bit is set holds the bus value after the next rising edge. A move from any register to any other completes in one cycle.
- R4: Several `ld_en` bits may be set together, and every selected register captures the same bus value.
- R5: When `rd_en` is all zero, `bus_float` is 1, `bus_valid` is 0, `bus_contend` is 0, and `bus_data` is zero.
- R6: When two or more `rd_en` bits are set, `bus_contend` is 1, `bus_valid` is 0, `bus_float` is 0, and `bus_data` is zero.
- R7: While `bus_valid` is 0, an asserted `ld_en` changes no register. Every register keeps its value.
- R8: Transfers run in both directions over the same bus. After A is moved to B, B can be moved back to A.
- R9: A register that is both source and destination in one cycle keeps its value.
- R10: With `wr_en` high, register `wr_sel` takes `wr_data` at the next edge. A direct write wins over a bus load to the same register. Other registers selected by `ld_en` still load from the bus in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | NREG | Source select, one bit per register |
| ld_en | input | NREG | Destination select, one bit per register |
| wr_en | input | 1 | Direct write enable |
| wr_sel | input | SELW | Index of the register to write directly |
| wr_data | input | DW | Value for the direct write |
| bus_data | output | DW | Current bus value, zero unless the bus is valid |
| bus_valid | output | 1 | Exactly one source is driving the bus |
| bus_float | output | 1 | No source is enabled |
| bus_contend | output | 1 | More than one source is enabled |
| regs_flat | output | NREG*DW | All register contents; register i is at bits i*DW +: DW |

## Verification
The bench checks four corner cases, each with the wrong behaviour it would catch:

- **Blocked loads.** Loads are attempted while the bus is floating and again while it is in contention. A design that let those loads through would write zero, or a merged OR of the sources, into the destination.
- **Self-transfer.** A register is read and loaded in the same cycle. This would expose a design that routed its load path anywhere other than the bus.
- **Write priority.** A direct write and a bus load hit the same register in the same cycle. A wrong priority would leave the bus value there instead of the written value.
- **Broadcast and reverse moves.** A single bus value is loaded into several registers at once, and a value is moved A to B and then B back to A. These cover incomplete load decoding and any bias towards one transfer direction.

// File: rtl/xfer_bus_pkg.sv
package xfer_bus_pkg;

    localparam int DEF_NREG = 4;
    localparam int DEF_DW   = 4;

    typedef enum logic [1:0] {
        BUS_DRIVEN  = 2'b00,
        BUS_FLOAT   = 2'b01,
        BUS_CONTEND = 2'b10
    } bus_state_e;

    function automatic bus_state_e classify_drivers(input int unsigned n);
        if (n == 0)
            return BUS_FLOAT;
        else if (n == 1)
            return BUS_DRIVEN;
        else
            return BUS_CONTEND;
    endfunction

endpackage

// File: rtl/xfer_bus_arbiter.sv
module xfer_bus_arbiter
    import xfer_bus_pkg::*;
#(
    parameter int NREG = DEF_NREG,
    parameter int DW   = DEF_DW
) (
    input  logic [NREG-1:0]    rd_en,
    input  logic [NREG*DW-1:0] regs_in,
    output logic [DW-1:0]      bus_data,
    output bus_state_e         bus_state
);

    logic [DW-1:0] merged;
    int unsigned   drivers;

    always_comb begin
        merged  = '0;
        drivers = 0;
        for (int i = 0; i < NREG; i++) begin
            if (rd_en[i]) begin
                merged  = merged | regs_in[i*DW +: DW];
                drivers = drivers + 1;
            end
        end
        bus_state = classify_drivers(drivers);
        bus_data  = (bus_state == BUS_DRIVEN) ? merged : '0;
    end

endmodule

// File: rtl/xfer_write_dec.sv
module xfer_write_dec
    import xfer_bus_pkg::*;
#(
    parameter int NREG = DEF_NREG,
    localparam int SELW = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic            wr_en,
    input  logic [SELW-1:0] wr_sel,
    output logic [NREG-1:0] wr_hit
);

    always_comb begin
        for (int i = 0; i < NREG; i++)
            wr_hit[i] = wr_en && (wr_sel == SELW'(i));
    end

endmodule

// File: rtl/xfer_reg_slot.sv
module xfer_reg_slot
    import xfer_bus_pkg::*;
#(
    parameter int DW = DEF_DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_hit,
    input  logic [DW-1:0] wr_data,
    input  logic          ld_req,
    input  logic          bus_ok,
    input  logic [DW-1:0] bus_data,
    output logic [DW-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (wr_hit)
            q <= wr_data;
        else if (ld_req && bus_ok)
            q <= bus_data;
    end

endmodule

// File: rtl/xfer_bus_unit.sv
module xfer_bus_unit
    import xfer_bus_pkg::*;
#(
    parameter int NREG = DEF_NREG,
    parameter int DW   = DEF_DW,
    localparam int SELW = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NREG-1:0]    rd_en,
    input  logic [NREG-1:0]    ld_en,
    input  logic               wr_en,
    input  logic [SELW-1:0]    wr_sel,
    input  logic [DW-1:0]      wr_data,
    output logic [DW-1:0]      bus_data,
    output logic               bus_valid,
    output logic               bus_float,
    output logic               bus_contend,
    output logic [NREG*DW-1:0] regs_flat
);

    typedef struct packed {
        logic [DW-1:0] data;
        bus_state_e    state;
    } bus_t;

    bus_t            bus;
    logic [NREG-1:0] wr_hit;

    xfer_bus_arbiter #(.NREG(NREG), .DW(DW)) u_arb (
        .rd_en     (rd_en),
        .regs_in   (regs_flat),
        .bus_data  (bus.data),
        .bus_state (bus.state)
    );

    xfer_write_dec #(.NREG(NREG)) u_wdec (
        .wr_en  (wr_en),
        .wr_sel (wr_sel),
        .wr_hit (wr_hit)
    );

    for (genvar g = 0; g < NREG; g++) begin : g_slot
        xfer_reg_slot #(.DW(DW)) u_slot (
            .clk      (clk),
            .rst      (rst),
            .wr_hit   (wr_hit[g]),
            .wr_data  (wr_data),
            .ld_req   (ld_en[g]),
            .bus_ok   (bus_valid),
            .bus_data (bus.data),
            .q        (regs_flat[g*DW +: DW])
        );
    end

    assign bus_data    = bus.data;
    assign bus_valid   = (bus.state == BUS_DRIVEN);
    assign bus_float   = (bus.state == BUS_FLOAT);
    assign bus_contend = (bus.state == BUS_CONTEND);

endmodule

// File: rtl/xfer_bus_unit_chk.sv
module xfer_bus_unit_chk #(
    parameter int NREG = 4,
    parameter int DW   = 4,
    localparam int SELW = (NREG > 1) ? $clog2(NREG) : 1
) (
    input logic               clk,
    input logic               rst,
    input logic [NREG-1:0]    rd_en,
    input logic [NREG-1:0]    ld_en,
    input logic               wr_en,
    input logic [SELW-1:0]    wr_sel,
    input logic [DW-1:0]      wr_data,
    input logic [DW-1:0]      bus_data,
    input logic               bus_valid,
    input logic               bus_float,
    input logic               bus_contend,
    input logic [NREG*DW-1:0] regs_flat
);

    // R1
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (regs_flat == '0));

    // R5
    a_r5_float_flag: assert property (@(posedge clk) disable iff (rst)
        (rd_en == '0) |-> (bus_float && !bus_valid && !bus_contend && bus_data == '0));

    // R6
    a_r6_contend_flag: assert property (@(posedge clk) disable iff (rst)
        ($countones(rd_en) > 1) |-> (bus_contend && !bus_valid && !bus_float && bus_data == '0));

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        // R2
        a_r2_source_on_bus: assert property (@(posedge clk) disable iff (rst)
            (rd_en == (NREG'(1) << g)) |-> (bus_valid && bus_data == regs_flat[g*DW +: DW]));

        // R3
        a_r3_capture: assert property (@(posedge clk) disable iff (rst)
            (bus_valid && ld_en[g] && !(wr_en && wr_sel == SELW'(g)))
            |=> (regs_flat[g*DW +: DW] == $past(bus_data)));

        // R7
        a_r7_hold: assert property (@(posedge clk) disable iff (rst)
            (!bus_valid && !(wr_en && wr_sel == SELW'(g)))
            |=> $stable(regs_flat[g*DW +: DW]));

        // R10
        a_r10_direct_write: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_sel == SELW'(g)) |=> (regs_flat[g*DW +: DW] == $past(wr_data)));
    end

endmodule

bind xfer_bus_unit xfer_bus_unit_chk #(.NREG(NREG), .DW(DW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .rd_en       (rd_en),
    .ld_en       (ld_en),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .wr_data     (wr_data),
    .bus_data    (bus_data),
    .bus_valid   (bus_valid),
    .bus_float   (bus_float),
    .bus_contend (bus_contend),
    .regs_flat   (regs_flat)
);

// File: tb/tb_xfer_bus_unit.sv
module tb_xfer_bus_unit;

    localparam int NREG = 4;
    localparam int DW   = 4;
    localparam int SELW = 2;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [NREG-1:0]    rd_en = '0;
    logic [NREG-1:0]    ld_en = '0;
    logic               wr_en = 1'b0;
    logic [SELW-1:0]    wr_sel = '0;
    logic [DW-1:0]      wr_data = '0;
    logic [DW-1:0]      bus_data;
    logic               bus_valid;
    logic               bus_float;
    logic               bus_contend;
    logic [NREG*DW-1:0] regs_flat;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    xfer_bus_unit #(.NREG(NREG), .DW(DW)) dut (
        .clk(clk), .rst(rst), .rd_en(rd_en), .ld_en(ld_en),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .bus_data(bus_data), .bus_valid(bus_valid), .bus_float(bus_float),
        .bus_contend(bus_contend), .regs_flat(regs_flat)
    );

    function automatic logic [DW-1:0] reg_at(int i);
        return regs_flat[i*DW +: DW];
    endfunction

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    // Inputs change 1 ns after a rising edge; outputs are sampled 1 ns later.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        rd_en = '0; ld_en = '0; wr_en = 1'b0;
    endtask

    task automatic direct_write(int idx, logic [DW-1:0] v);
        wr_en = 1'b1; wr_sel = SELW'(idx); wr_data = v;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1; idle();
        tick(); tick();
        for (int i = 0; i < NREG; i++) chk("R1 reset reg", reg_at(i), 0);
        rst = 1'b0;
        #1;
        chk("R5 float after reset", {bus_float, bus_valid, bus_contend}, 3'b100);
    endtask

    task automatic t_seed();
        direct_write(0, 4'hA);
        direct_write(1, 4'h3);
        direct_write(2, 4'h6);
        direct_write(3, 4'hC);
        chk("R10 seed r0", reg_at(0), 4'hA);
        chk("R10 seed r3", reg_at(3), 4'hC);
    endtask

    task automatic t_a_to_b();
        rd_en = 4'b0001; ld_en = 4'b0010;
        #1;
        chk("R2 bus shows A", bus_data, 4'hA);
        chk("R2 bus valid", {bus_valid, bus_float, bus_contend}, 3'b100);
        tick(); idle();
        chk("R3 B after move", reg_at(1), 4'hA);
        chk("R3 A unchanged", reg_at(0), 4'hA);
    endtask

    task automatic t_b_to_a();
        direct_write(1, 4'h5);
        rd_en = 4'b0010; ld_en = 4'b0001;
        tick(); idle();
        chk("R8 A after reverse move", reg_at(0), 4'h5);
        rd_en = 4'b0001; ld_en = 4'b0100;
        tick(); idle();
        chk("R8 C from A", reg_at(2), 4'h5);
    endtask

    task automatic t_float();
        rd_en = '0; ld_en = 4'b1111;
        #1;
        chk("R5 float flags", {bus_float, bus_valid, bus_contend}, 3'b100);
        chk("R5 float data", bus_data, 0);
        tick(); idle();
        chk("R7 r0 held under float", reg_at(0), 4'h5);
        chk("R7 r3 held under float", reg_at(3), 4'hC);
    endtask

    task automatic t_contend();
        rd_en = 4'b1010; ld_en = 4'b0101;
        #1;
        chk("R6 contend flags", {bus_contend, bus_valid, bus_float}, 3'b100);
        chk("R6 contend data", bus_data, 0);
        tick(); idle();
        chk("R7 r0 held under contention", reg_at(0), 4'h5);
        chk("R7 r2 held under contention", reg_at(2), 4'h5);
        rd_en = 4'b1111;
        #1;
        chk("R6 all sources", bus_contend, 1);
        idle();
    endtask

    task automatic t_self();
        rd_en = 4'b1000; ld_en = 4'b1000;
        tick(); idle();
        chk("R9 self move keeps value", reg_at(3), 4'hC);
    endtask

    task automatic t_broadcast();
        rd_en = 4'b1000; ld_en = 4'b0111;
        tick(); idle();
        chk("R4 bcast r0", reg_at(0), 4'hC);
        chk("R4 bcast r1", reg_at(1), 4'hC);
        chk("R4 bcast r2", reg_at(2), 4'hC);
    endtask

    task automatic t_wr_priority();
        direct_write(3, 4'h9);
        rd_en = 4'b1000; ld_en = 4'b0011;
        wr_en = 1'b1; wr_sel = 2'd1; wr_data = 4'h7;
        tick(); idle();
        chk("R10 write wins over bus load", reg_at(1), 4'h7);
        chk("R10 other dest loads bus", reg_at(0), 4'h9);
        rd_en = '0; ld_en = '0;
        wr_en = 1'b1; wr_sel = 2'd2; wr_data = 4'h1;
        tick(); idle();
        chk("R10 write while bus floats", reg_at(2), 4'h1);
    endtask

    task automatic t_reset_again();
        rst = 1'b1;
        tick();
        rst = 1'b0;
        chk("R1 second reset", regs_flat, 0);
    endtask

    initial begin
        t_reset();
        t_seed();
        t_a_to_b();
        t_b_to_a();
        t_float();
        t_contend();
        t_self();
        t_broadcast();
        t_wr_priority();
        t_reset_again();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #40000;
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule